// File: doc/BRIEF.md
# CRC Memory Scanner with Descriptor Fetch

This block computes a cyclic redundancy check over a region of memory without help from a processor. Software writes the memory address of a small descriptor into the block. The block reads two words from that descriptor: the start address of the region and a control word. The control word gives the number of data items ("beads"), their width and an interrupt enable. The block then reads the beads one after another over a simple request/valid memory port. It folds each returned bead into the CRC register, taking the data bits from the least significant bit upward.

One of three reflected polynomials is chosen by a select input: CRC-32, CRC-32C or the 16-bit CCITT polynomial. The CRC register is preset to all ones only when software pulses a preset strobe. A finished transfer does not clear the register, so several regions can be chained into a single checksum. When a transfer ends, a sticky done flag is set. An interrupt is raised if the control word enabled it.

Top module: `crcMemScan`

## Requirements
- R1: After reset, `busy`, `doneFlag` and `irq` are 0, and `crcOut` reads 0xFFFFFFFF when `polySel` is 0.
- R2: A pulse on `descWr` while idle latches `descPtrIn` and starts a transfer. The block first reads the byte address `ptr`, which holds the start address. It then reads `ptr+4`, which holds the control word: bits [15:0] are the bead count, bits [17:16] the width code and bit 18 the interrupt enable.
- R3: Width codes are 0 for byte, 1 for halfword and 2 for word; code 3 behaves as word. The bead address starts at the start address and advances by 1, 2 or 4 after each bead. The bead value is taken from the low 8, 16 or 32 bits of `memRdata`.
- R4: Each bead is folded into the CRC from its bit 0 upward. `polySel` 0 uses reflected 0xEDB88320, 1 uses 0x82F63B78, and 2 or 3 use 0x8408. In the 16-bit modes only the low 16 bits take part, and `crcOut[31:16]` reads 0.
- R5: A pulse on `crcRst` sets the CRC register to all ones. If it coincides with a fold, the preset wins. Nothing else resets the register between transfers, so successive transfers chain.
- R6: A bead count of zero completes the transfer after the two descriptor reads, with no bead read.
- R7: `doneFlag` is set when a transfer completes and stays set until `doneClr` is pulsed. If a set and a clear coincide, the set wins.
- R8: `irq` is high exactly while `doneFlag` is set and the last fetched control word had its interrupt enable set.
- R9: A `descWr` pulse while `busy` is high is ignored: the running transfer and its read count and result are unaffected.
- R10: `memReq` is a one-cycle pulse with at most one read outstanding. The block waits any number of cycles for `memValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descWr | input | 1 | Strobe: write descriptor pointer and start |
| descPtrIn | input | 32 | Descriptor byte address |
| polySel | input | 2 | Polynomial select |
| crcRst | input | 1 | Strobe: preset CRC register to all ones |
| doneClr | input | 1 | Strobe: clear the done flag |
| memReq | output | 1 | Read request pulse |
| memAddr | output | 32 | Read byte address |
| memValid | input | 1 | Read data valid pulse |
| memRdata | input | 32 | Read data, bead in the low lanes |
| busy | output | 1 | Transfer in progress |
| doneFlag | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | Interrupt request |
| crcOut | output | 32 | Current CRC register (low 16 bits in 16-bit modes) |

## Verification
The string "123456789" is run as bytes under each polynomial against published check values. This separates a wrong polynomial constant, a wrong bit order and a wrong 16-bit masking. The same bytes are then read as halfwords and words, and the results must match the byte result. A mismatch there exposes lane, step or count errors.

Directed cases cover several further points:
- a zero-length descriptor, counting the memory requests;
- a chained pair of transfers without a preset;
- a descriptor write during a transfer;
- clearing the done flag with the interrupt enable on and off.

Random transfers then vary the width, length, polynomial, start alignment and memory latency. Each result is compared with a reference CRC computed in the bench.

// File: rtl/crcScanPkg.sv
package crcScanPkg;

  typedef enum logic [1:0] {
    BW_BYTE = 2'd0,
    BW_HALF = 2'd1,
    BW_WORD = 2'd2,
    BW_WRSV = 2'd3
  } beadW_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_ADDR, ST_FETCH_CTRL, ST_READ, ST_WAIT_DATA, ST_DONE
  } scanState_e;

  typedef enum logic [1:0] {PH_ADDR, PH_CTRL, PH_BEAD} rdPhase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   preset;
    logic   fold;
    beadW_e width;
  } dpCmd_t;

  localparam logic [31:0] POLY_32  = 32'hEDB88320;
  localparam logic [31:0] POLY_32C = 32'h82F63B78;
  localparam logic [31:0] POLY_16  = 32'h00008408;

  function automatic int beadBits(input beadW_e w);
    case (w)
      BW_BYTE: return 8;
      BW_HALF: return 16;
      default: return 32;
    endcase
  endfunction

  // reflected CRC update, data bit 0 first
  function automatic logic [31:0] foldBead(input logic [31:0] crcIn,
                                           input logic [31:0] data,
                                           input int nBits,
                                           input logic [1:0] sel);
    logic [31:0] c;
    logic [31:0] poly;
    logic        fb;
    poly = (sel == 2'd0) ? POLY_32 : (sel == 2'd1) ? POLY_32C : POLY_16;
    c = sel[1] ? (crcIn & 32'h0000FFFF) : crcIn;
    for (int i = 0; i < 32; i++) begin
      if (i < nBits) begin
        fb = c[0] ^ data[i];
        c  = {1'b0, c[31:1]} ^ (fb ? poly : 32'h0);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/crcScanCtrl.sv
module crcScanCtrl
  import crcScanPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descWr,
  input  logic [ADDR_W-1:0] descPtrIn,
  input  logic              crcRst,
  input  logic              doneClr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memRdata,
  output logic              busy,
  output logic              doneFlag,
  output logic              irq,
  output dpCmd_t            cmd
);
  localparam int WID_LSB = SIZE_W;
  localparam int IE_BIT  = SIZE_W + 2;
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4);

  scanState_e        state;
  rdPhase_e          phase;
  logic [ADDR_W-1:0] descPtr;
  logic [ADDR_W-1:0] curAddr;
  logic [SIZE_W-1:0] remain;
  beadW_e            beadW;
  logic              irqEn;
  logic [ADDR_W-1:0] step;
  logic              finish;

  always_comb begin
    case (beadW)
      BW_BYTE: step = ADDR_W'(1);
      BW_HALF: step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      descPtr <= '0;
      curAddr <= '0;
      remain  <= '0;
      beadW   <= BW_BYTE;
      irqEn   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (descWr) begin
          descPtr <= descPtrIn;
          state   <= ST_FETCH_ADDR;
        end
        ST_FETCH_ADDR: begin phase <= PH_ADDR; state <= ST_WAIT_DATA; end
        ST_FETCH_CTRL: begin phase <= PH_CTRL; state <= ST_WAIT_DATA; end
        ST_READ:       begin phase <= PH_BEAD; state <= ST_WAIT_DATA; end
        ST_WAIT_DATA: if (memValid) begin
          case (phase)
            PH_ADDR: begin
              curAddr <= memRdata[ADDR_W-1:0];
              state   <= ST_FETCH_CTRL;
            end
            PH_CTRL: begin
              remain <= memRdata[SIZE_W-1:0];
              beadW  <= beadW_e'(memRdata[WID_LSB +: 2]);
              irqEn  <= memRdata[IE_BIT];
              state  <= (memRdata[SIZE_W-1:0] == '0) ? ST_DONE : ST_READ;
            end
            default: begin
              curAddr <= curAddr + step;
              remain  <= remain - 1'b1;
              state   <= (remain == SIZE_W'(1)) ? ST_DONE : ST_READ;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign finish = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        doneFlag <= 1'b0;
    else if (finish)  doneFlag <= 1'b1;
    else if (doneClr) doneFlag <= 1'b0;
  end

  always_comb begin
    memReq = (state == ST_FETCH_ADDR) || (state == ST_FETCH_CTRL) || (state == ST_READ);
    case (state)
      ST_FETCH_ADDR: memAddr = descPtr;
      ST_FETCH_CTRL: memAddr = descPtr + CTRL_OFS;
      default:       memAddr = curAddr;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign irq        = doneFlag & irqEn;
  assign cmd.preset = crcRst;
  assign cmd.fold   = (state == ST_WAIT_DATA) && memValid && (phase == PH_BEAD);
  assign cmd.width  = beadW;

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && doneFlag && !finish) |=> !doneFlag);
  // R7
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(busy));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !finish && descWr) |=> busy);
endmodule

// File: rtl/crcScanData.sv
module crcScanData
  import crcScanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCmd_t      cmd,
  input  logic [1:0]  polySel,
  input  logic [31:0] memRdata,
  output logic [31:0] crcOut
);
  logic [31:0] crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           crcReg <= '1;
    else if (cmd.preset) crcReg <= '1;
    else if (cmd.fold)   crcReg <= foldBead(crcReg, memRdata, beadBits(cmd.width), polySel);
  end

  assign crcOut = polySel[1] ? {16'h0, crcReg[15:0]} : crcReg;

  // R5
  crc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.preset && !cmd.fold) |=> $stable(crcReg));
  // R5
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.preset |=> (crcReg == 32'hFFFFFFFF));
endmodule

// File: rtl/crcMemScan.sv
module crcMemScan
  import crcScanPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descWr,
  input  logic [ADDR_W-1:0] descPtrIn,
  input  logic [1:0]        polySel,
  input  logic              crcRst,
  input  logic              doneClr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memRdata,
  output logic              busy,
  output logic              doneFlag,
  output logic              irq,
  output logic [31:0]       crcOut
);
  dpCmd_t cmd;

  crcScanCtrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .descWr(descWr), .descPtrIn(descPtrIn),
    .crcRst(crcRst), .doneClr(doneClr), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memRdata(memRdata), .busy(busy),
    .doneFlag(doneFlag), .irq(irq), .cmd(cmd)
  );

  crcScanData uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .polySel(polySel),
    .memRdata(memRdata), .crcOut(crcOut)
  );
endmodule

// File: tb/sim_crcMemScan.sv
module sim_crcMemScan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descWr = 1'b0;
  logic [31:0] descPtrIn = '0;
  logic [1:0]  polySel = 2'd0;
  logic        crcRst = 1'b0;
  logic        doneClr = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        busy, doneFlag, irq;
  logic [31:0] crcOut;

  int total = 0;
  int bad = 0;
  int reqCount = 0;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  crcMemScan u0 (
    .clk(clk), .rstN(rstN), .descWr(descWr), .descPtrIn(descPtrIn),
    .polySel(polySel), .crcRst(crcRst), .doneClr(doneClr),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memRdata(memRdata), .busy(busy), .doneFlag(doneFlag), .irq(irq),
    .crcOut(crcOut)
  );

  // memory model: one outstanding read, random latency
  logic        pending = 1'b0;
  logic [31:0] pendAddr = '0;
  int          lat = 0;

  function automatic logic [31:0] rdWord(input logic [31:0] a);
    return {mem[(a+3) & 12'hFFF], mem[(a+2) & 12'hFFF], mem[(a+1) & 12'hFFF], mem[a & 12'hFFF]};
  endfunction

  always @(posedge clk) begin
    memValid <= 1'b0;
    if (memReq) begin
      pending = 1'b1; pendAddr = memAddr; lat = $urandom_range(0, 3); reqCount++;
    end else if (pending) begin
      if (lat == 0) begin
        memValid <= 1'b1; memRdata <= rdWord(pendAddr); pending = 1'b0;
      end else lat--;
    end
  end

  // reference CRC, one byte at a time
  function automatic logic [31:0] refByte(input logic [31:0] c0, input logic [7:0] b, input logic [1:0] sel);
    logic [31:0] c, p;
    p = (sel == 0) ? 32'hEDB88320 : (sel == 1) ? 32'h82F63B78 : 32'h8408;
    c = sel[1] ? {16'h0, c0[15:0]} : c0;
    for (int k = 0; k < 8; k++) c = c[0] ^ b[k] ? (c >> 1) ^ p : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] refRegion(input logic [31:0] c0, input int start, input int cnt,
                                            input int wcode, input logic [1:0] sel);
    logic [31:0] c;
    int bytesPer;
    bytesPer = (wcode == 0) ? 1 : (wcode == 1) ? 2 : 4;
    c = c0;
    for (int i = 0; i < cnt * bytesPer; i++) c = refByte(c, mem[(start + i) & 12'hFFF], sel);
    return c;
  endfunction

  function automatic logic [31:0] view(input logic [31:0] c, input logic [1:0] sel);
    return sel[1] ? {16'h0, c[15:0]} : c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic putWord(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[(a + i) & 12'hFFF] = v[8*i +: 8];
  endtask

  task automatic setDesc(input int ptr, input int start, input int cnt, input int wcode, input bit ie);
    putWord(ptr, start);
    putWord(ptr + 4, {13'h0, ie, wcode[1:0], cnt[15:0]});
  endtask

  task automatic presetCrc();
    @(negedge clk); crcRst = 1'b1;
    @(negedge clk); crcRst = 1'b0;
  endtask

  task automatic clearDone();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
  endtask

  task automatic runDesc(input int ptr);
    int guard;
    @(negedge clk); descPtrIn = ptr; descWr = 1'b1;
    @(negedge clk); descWr = 1'b0;
    guard = 0;
    while (!doneFlag && guard < 2000) begin @(negedge clk); guard++; end
    if (guard >= 2000) chk("R2 timeout", 32'h0, 32'h1);
  endtask

  logic [31:0] expC;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom(32'd1234 + i));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 doneFlag", doneFlag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 crcOut", crcOut, 32'hFFFFFFFF);
    rstN = 1'b1;
    @(negedge clk);

    // "123456789" at 0x200
    for (int i = 0; i < 9; i++) mem[12'h200 + i] = 8'h31 + 8'(i);
    // R2 R4 byte beads, known check values
    for (int s = 0; s < 3; s++) begin
      polySel = 2'(s);
      setDesc(12'h040, 12'h200, 9, 0, 1'b0);
      presetCrc();
      runDesc(12'h040);
      expC = (s == 0) ? 32'h340BC6D9 : (s == 1) ? 32'h1CF96D7C : 32'h6F91;
      chk("R4 check value", crcOut, expC);
      clearDone();
    end
    // R4 select 3 behaves as CRC-16
    polySel = 2'd3;
    presetCrc(); runDesc(12'h040);
    chk("R4 sel3", crcOut, 32'h6F91);
    clearDone();

    // R3 halfword and word beads over 8 bytes equal byte reference
    polySel = 2'd0;
    setDesc(12'h050, 12'h300, 4, 1, 1'b0);
    presetCrc(); runDesc(12'h050);
    chk("R3 halfword", crcOut, refRegion('1, 12'h300, 4, 1, 0));
    clearDone();
    setDesc(12'h050, 12'h300, 2, 2, 1'b0);
    presetCrc(); runDesc(12'h050);
    chk("R3 word", crcOut, refRegion('1, 12'h300, 2, 2, 0));
    clearDone();
    setDesc(12'h050, 12'h300, 2, 3, 1'b0);
    presetCrc(); runDesc(12'h050);
    chk("R3 code3 as word", crcOut, refRegion('1, 12'h300, 2, 2, 0));
    clearDone();

    // R6 zero count: two reads only, crc untouched
    setDesc(12'h060, 12'h300, 0, 0, 1'b1);
    presetCrc();
    reqCount = 0;
    runDesc(12'h060);
    chk("R6 reads", reqCount, 2);
    chk("R6 crc", crcOut, 32'hFFFFFFFF);
    // R8 irq with enable
    chk("R8 irq on", irq, 1);
    // R7 sticky then clear
    repeat (5) @(negedge clk);
    chk("R7 sticky", doneFlag, 1);
    clearDone();
    chk("R7 cleared", doneFlag, 0);
    chk("R8 irq off after clear", irq, 0);

    // R8 no irq when disabled
    setDesc(12'h060, 12'h300, 1, 0, 1'b0);
    runDesc(12'h060);
    chk("R8 irq disabled", irq, 0);
    clearDone();

    // R5 chaining two regions without preset
    polySel = 2'd1;
    setDesc(12'h070, 12'h400, 5, 0, 1'b0);
    setDesc(12'h080, 12'h405, 3, 1, 1'b0);
    presetCrc();
    runDesc(12'h070); clearDone();
    runDesc(12'h080); clearDone();
    chk("R5 chain", crcOut, refRegion('1, 12'h400, 11, 0, 1));

    // R9 descriptor write while busy ignored
    setDesc(12'h090, 12'h500, 6, 0, 1'b0);
    setDesc(12'h0A0, 12'h600, 0, 0, 1'b1);
    presetCrc();
    reqCount = 0;
    @(negedge clk); descPtrIn = 12'h090; descWr = 1'b1;
    @(negedge clk); descWr = 1'b0;
    repeat (4) @(negedge clk);
    descPtrIn = 12'h0A0; descWr = 1'b1;
    @(negedge clk); descWr = 1'b0;
    while (!doneFlag) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R9 reads", reqCount, 8);
    chk("R9 crc", crcOut, refRegion('1, 12'h500, 6, 0, 1));
    chk("R9 irq", irq, 0);
    clearDone();

    // R7 set wins over clear: clear held through completion
    setDesc(12'h0B0, 12'h300, 0, 0, 1'b0);
    @(negedge clk); descPtrIn = 12'h0B0; descWr = 1'b1;
    @(negedge clk); descWr = 1'b0; doneClr = 1'b1;
    while (busy) @(negedge clk);
    doneClr = 1'b0;
    chk("R7 set wins", doneFlag, 1);
    clearDone();

    // R3 R4 R10 random transfers
    for (int t = 0; t < 12; t++) begin
      int st, cnt, wc;
      logic [1:0] ps;
      st = $urandom_range(12'h800, 12'hE00);
      cnt = $urandom_range(1, 20);
      wc = $urandom_range(0, 2);
      ps = 2'($urandom_range(0, 3));
      polySel = ps;
      setDesc(12'h0C0, st, cnt, wc, 1'b0);
      presetCrc(); runDesc(12'h0C0);
      chk("R4 random", crcOut, view(refRegion('1, st, cnt, wc, ps), ps));
      clearDone();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule